// File: doc/BRIEF.md
# DMA Channel Register Bank

This block is the host-facing register bank for a small group of descriptor-driven DMA channels. Each channel has a control port, a status word, a command-pointer register and three condition-select words (for interrupt, branch and wait decisions). The host reaches every register with 32-bit word accesses. The address picks the channel and the register.

A control write does not store anything itself. Its upper half is a bit mask and its lower half is the new values. The mask says which status bits the write may change. After the merge, the block settles the ACTIVE and DEAD bits from the RUN, PAUSE and WAKE settings. When FLUSH is requested, the block raises a one-cycle flush pulse and drops FLUSH again. Any control write that leaves the channel active sends a one-cycle kick to the sequencer.

The command pointer can only be written while the channel is idle. An accepted value is aligned down to 16 bytes, and the write raises a descriptor-fetch pulse. The sequencer can replace a channel's status word through a dedicated update port.

Top module: `dma_chan_regs`

## Requirements
- R1: Reset clears every register of every channel and holds the flush, kick and fetch pulses low.
- R2: A control write uses mask = data[31:16] and value = data[15:0]. Only RUN (bit 15), PAUSE (bit 14), FLUSH (bit 13), WAKE (bit 12) and device status (bits 3:0) can change, as new = (value & mask) | (old & ~mask). DEAD (bit 11), ACTIVE (bit 10) and BT (bit 8) ignore the mask and value.
- R3: After the merge, the following rules apply in this order. WAKE set forces ACTIVE. RUN set forces ACTIVE and clears DEAD. PAUSE set clears ACTIVE.
- R4: A control write that takes RUN from 1 to 0 clears both ACTIVE and DEAD.
- R5: If FLUSH is set after the merge, flushReq for that channel is high for exactly the one cycle after the write, and FLUSH reads back as 0.
- R6: kick for a channel is high for the one cycle after a control write whose resulting status has ACTIVE set. Otherwise it is low.
- R7: A command-pointer write is ignored while ACTIVE is set. An accepted write stores data with bits 3:0 cleared and pulses fetchReq for that channel for one cycle.
- R8: The register map uses word offsets: control 0x00, status 0x04, pointer-high 0x08, command pointer 0x0C, interrupt select 0x10, branch select 0x14, wait select 0x18, transfer mode 0x1C. Control, pointer-high and transfer mode always read 0. Status reads as its 16-bit value, zero-extended. The three selects and the command pointer read back as stored.
- R9: The channel number is busAddr[ADDR_W-1:CH_SHIFT] and the register is busAddr[CH_SHIFT-1:2]. An access is ignored (no write, read returns 0) in any of these cases: busWordAccess is low, busAddr[1:0] is nonzero, the register offset is outside the map, or the channel number is not below NCH.
- R10: A pulse on seqStatWe overwrites the status of channel seqStatCh with seqStatData. A host control or status write to the same channel in the same cycle takes precedence.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address (channel and register) |
| busWrEn | input | 1 | Write strobe |
| busWordAccess | input | 1 | High when the access is a full 32-bit word |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr (combinational) |
| seqStatWe | input | 1 | Sequencer status update strobe |
| seqStatCh | input | CH_W | Channel for the status update |
| seqStatData | input | 16 | New status word |
| chStatus | output | NCH*16 | Status word per channel |
| chCmdPtr | output | NCH*32 | Command pointer per channel |
| chIntrSel | output | NCH*32 | Interrupt condition select per channel |
| chBranchSel | output | NCH*32 | Branch condition select per channel |
| chWaitSel | output | NCH*32 | Wait condition select per channel |
| flushReq | output | NCH | One-cycle flush request per channel |
| kick | output | NCH | One-cycle sequencer kick per channel |
| fetchReq | output | NCH | One-cycle descriptor fetch request per channel |

## Verification
The assertions rely on these assumptions about the inputs:
- Bus inputs are stable around the clock edge.
- The sequencer never changes the command pointer, so a rejected pointer write must leave it unchanged.
- A sequencer update that collides with a host write to the same channel loses.

The stimulus drives every input on the falling edge, uses only the defined update port to set DEAD and ACTIVE, and creates a collision only in the one scenario that checks the precedence rule.

// File: rtl/dma_chan_regs_pkg.sv
package dma_chan_regs_pkg;

  // Status bit positions
  localparam int RUN_B    = 15;
  localparam int PAUSE_B  = 14;
  localparam int FLUSH_B  = 13;
  localparam int WAKE_B   = 12;
  localparam int DEAD_B   = 11;
  localparam int ACTIVE_B = 10;
  localparam int BT_B     = 8;
  localparam int DEV_W    = 4;

  // Bits a control write may change: run, pause, flush, wake, device status
  localparam logic [15:0] CTL_WRITABLE = 16'hF00F;

  typedef enum logic [2:0] {
    REG_CTL   = 3'd0,
    REG_STAT  = 3'd1,
    REG_PTRHI = 3'd2,
    REG_PTR   = 3'd3,
    REG_INTR  = 3'd4,
    REG_BR    = 3'd5,
    REG_WAIT  = 3'd6,
    REG_XFER  = 3'd7
  } regIdx_t;

  typedef struct packed {
    logic ctl;
    logic stat;
    logic ptr;
    logic intr;
    logic br;
    logic waitSel;
  } wrStrobe_t;

endpackage

// File: rtl/dma_chan_regs_ctl.sv
module dma_chan_regs_ctl
  import dma_chan_regs_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CH_SHIFT = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_SHIFT + CH_W
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busWordAccess,
  output wrStrobe_t         strb,
  output logic [CH_W-1:0]   chIdx,
  output regIdx_t           regIdx,
  output logic              accessOk
);

  logic [CH_SHIFT-3:0] wordIdx;
  logic inMap;
  logic chOk;
  logic wrOk;

  assign chIdx   = busAddr[ADDR_W-1:CH_SHIFT];
  assign wordIdx = busAddr[CH_SHIFT-1:2];
  assign regIdx  = regIdx_t'(wordIdx[2:0]);
  assign inMap   = (wordIdx >> 3) == '0;
  assign chOk    = {1'b0, chIdx} < (CH_W+1)'(NCH);
  assign accessOk = busWordAccess && (busAddr[1:0] == 2'b00) && inMap && chOk;
  assign wrOk    = busWrEn && accessOk;

  always_comb begin
    strb = '0;
    if (wrOk) begin
      unique case (regIdx)
        REG_CTL:  strb.ctl     = 1'b1;
        REG_STAT: strb.stat    = 1'b1;
        REG_PTR:  strb.ptr     = 1'b1;
        REG_INTR: strb.intr    = 1'b1;
        REG_BR:   strb.br      = 1'b1;
        REG_WAIT: strb.waitSel = 1'b1;
        default:  strb         = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_regs_dp.sv
module dma_chan_regs_dp
  import dma_chan_regs_pkg::*;
#(
  parameter int NCH = 2,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  wrStrobe_t         strb,
  input  logic [CH_W-1:0]   chIdx,
  input  regIdx_t           regIdx,
  input  logic              accessOk,
  input  logic [31:0]       wrData,
  input  logic              seqStatWe,
  input  logic [CH_W-1:0]   seqStatCh,
  input  logic [15:0]       seqStatData,
  output logic [31:0]       rdData,
  output logic [NCH*16-1:0] chStatus,
  output logic [NCH*32-1:0] chCmdPtr,
  output logic [NCH*32-1:0] chIntrSel,
  output logic [NCH*32-1:0] chBranchSel,
  output logic [NCH*32-1:0] chWaitSel,
  output logic [NCH-1:0]    flushReq,
  output logic [NCH-1:0]    kick,
  output logic [NCH-1:0]    fetchReq
);

  logic [15:0] statArr [NCH];
  logic [31:0] ptrArr  [NCH];
  logic [31:0] intrArr [NCH];
  logic [31:0] brArr   [NCH];
  logic [31:0] waitArr [NCH];

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [15:0] statQ;
    logic [31:0] ptrQ, intrQ, brQ, waitQ;
    logic [15:0] ctlMask, ctlVal, ctlNext;
    logic        flushNow;
    logic        hit;

    assign hit = (chIdx == CH_W'(i));

    // Masked merge followed by the derived ACTIVE/DEAD rules
    always_comb begin
      ctlMask  = wrData[31:16] & CTL_WRITABLE;
      ctlVal   = wrData[15:0] & CTL_WRITABLE;
      ctlNext  = (ctlVal & ctlMask) | (statQ & ~ctlMask);
      if (ctlNext[WAKE_B]) ctlNext[ACTIVE_B] = 1'b1;
      if (ctlNext[RUN_B]) begin
        ctlNext[ACTIVE_B] = 1'b1;
        ctlNext[DEAD_B]   = 1'b0;
      end
      if (ctlNext[PAUSE_B]) ctlNext[ACTIVE_B] = 1'b0;
      if (statQ[RUN_B] && !ctlNext[RUN_B]) begin
        ctlNext[ACTIVE_B] = 1'b0;
        ctlNext[DEAD_B]   = 1'b0;
      end
      flushNow = ctlNext[FLUSH_B];
      ctlNext[FLUSH_B] = 1'b0;
    end

    always_ff @(posedge clk) begin
      if (!rstN) begin
        statQ       <= '0;
        ptrQ        <= '0;
        intrQ       <= '0;
        brQ         <= '0;
        waitQ       <= '0;
        flushReq[i] <= 1'b0;
        kick[i]     <= 1'b0;
        fetchReq[i] <= 1'b0;
      end else begin
        flushReq[i] <= 1'b0;
        kick[i]     <= 1'b0;
        fetchReq[i] <= 1'b0;
        if (hit && strb.ctl) begin
          statQ       <= ctlNext;
          flushReq[i] <= flushNow;
          kick[i]     <= ctlNext[ACTIVE_B];
        end else if (hit && strb.stat) begin
          statQ <= wrData[15:0];
        end else if (seqStatWe && seqStatCh == CH_W'(i)) begin
          statQ <= seqStatData;
        end
        if (hit && strb.ptr && !statQ[ACTIVE_B]) begin
          ptrQ        <= {wrData[31:4], 4'b0000};
          fetchReq[i] <= 1'b1;
        end
        if (hit && strb.intr)    intrQ <= wrData;
        if (hit && strb.br)      brQ   <= wrData;
        if (hit && strb.waitSel) waitQ <= wrData;
      end
    end

    assign statArr[i] = statQ;
    assign ptrArr[i]  = ptrQ;
    assign intrArr[i] = intrQ;
    assign brArr[i]   = brQ;
    assign waitArr[i] = waitQ;
    assign chStatus[i*16 +: 16]    = statQ;
    assign chCmdPtr[i*32 +: 32]    = ptrQ;
    assign chIntrSel[i*32 +: 32]   = intrQ;
    assign chBranchSel[i*32 +: 32] = brQ;
    assign chWaitSel[i*32 +: 32]   = waitQ;
  end

  always_comb begin
    rdData = '0;
    if (accessOk) begin
      unique case (regIdx)
        REG_STAT: rdData = {16'h0000, statArr[chIdx]};
        REG_PTR:  rdData = ptrArr[chIdx];
        REG_INTR: rdData = intrArr[chIdx];
        REG_BR:   rdData = brArr[chIdx];
        REG_WAIT: rdData = waitArr[chIdx];
        default:  rdData = '0;
      endcase
    end
  end

endmodule

// File: rtl/dma_chan_regs.sv
module dma_chan_regs
  import dma_chan_regs_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CH_SHIFT = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_SHIFT + CH_W
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic              busWordAccess,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData,
  input  logic              seqStatWe,
  input  logic [CH_W-1:0]   seqStatCh,
  input  logic [15:0]       seqStatData,
  output logic [NCH*16-1:0] chStatus,
  output logic [NCH*32-1:0] chCmdPtr,
  output logic [NCH*32-1:0] chIntrSel,
  output logic [NCH*32-1:0] chBranchSel,
  output logic [NCH*32-1:0] chWaitSel,
  output logic [NCH-1:0]    flushReq,
  output logic [NCH-1:0]    kick,
  output logic [NCH-1:0]    fetchReq
);

  wrStrobe_t       strb;
  logic [CH_W-1:0] chIdx;
  regIdx_t         regIdx;
  logic            accessOk;

  dma_chan_regs_ctl #(.NCH(NCH), .CH_SHIFT(CH_SHIFT)) ctl_i (
    .busAddr       (busAddr),
    .busWrEn       (busWrEn),
    .busWordAccess (busWordAccess),
    .strb          (strb),
    .chIdx         (chIdx),
    .regIdx        (regIdx),
    .accessOk      (accessOk)
  );

  dma_chan_regs_dp #(.NCH(NCH)) dp_i (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .chIdx       (chIdx),
    .regIdx      (regIdx),
    .accessOk    (accessOk),
    .wrData      (busWrData),
    .seqStatWe   (seqStatWe),
    .seqStatCh   (seqStatCh),
    .seqStatData (seqStatData),
    .rdData      (busRdData),
    .chStatus    (chStatus),
    .chCmdPtr    (chCmdPtr),
    .chIntrSel   (chIntrSel),
    .chBranchSel (chBranchSel),
    .chWaitSel   (chWaitSel),
    .flushReq    (flushReq),
    .kick        (kick),
    .fetchReq    (fetchReq)
  );

endmodule

// File: rtl/dma_chan_regs_chk.sv
module dma_chan_regs_chk
  import dma_chan_regs_pkg::*;
#(
  parameter int NCH = 2,
  parameter int CH_SHIFT = 8,
  localparam int CH_W = (NCH > 1) ? $clog2(NCH) : 1,
  localparam int ADDR_W = CH_SHIFT + CH_W
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic              busWordAccess,
  input logic [31:0]       busWrData,
  input logic [31:0]       busRdData,
  input logic              seqStatWe,
  input logic [CH_W-1:0]   seqStatCh,
  input logic [15:0]       seqStatData,
  input logic [NCH*16-1:0] chStatus,
  input logic [NCH*32-1:0] chCmdPtr,
  input logic [NCH*32-1:0] chIntrSel,
  input logic [NCH*32-1:0] chBranchSel,
  input logic [NCH*32-1:0] chWaitSel,
  input logic [NCH-1:0]    flushReq,
  input logic [NCH-1:0]    kick,
  input logic [NCH-1:0]    fetchReq
);

  logic ctlRead;
  assign ctlRead = busWordAccess && (busAddr[CH_SHIFT-1:0] == '0);

  // R8: the control offset never returns data
  assert_ctl_reads_zero_R8: assert property (@(posedge clk) disable iff (!rstN)
    ctlRead |-> busRdData == 32'h0);

  for (genvar i = 0; i < NCH; i++) begin : g_chk
    logic ctlWr, ptrWr;
    assign ctlWr = busWrEn && busWordAccess && busAddr[ADDR_W-1:CH_SHIFT] == CH_W'(i)
                   && busAddr[CH_SHIFT-1:0] == CH_SHIFT'(0);
    assign ptrWr = busWrEn && busWordAccess && busAddr[ADDR_W-1:CH_SHIFT] == CH_W'(i)
                   && busAddr[CH_SHIFT-1:0] == CH_SHIFT'(12);

    assert_ptr_locked_R7: assert property (@(posedge clk) disable iff (!rstN)
      (ptrWr && chStatus[i*16+ACTIVE_B]) |=> $stable(chCmdPtr[i*32 +: 32]));

    assert_ptr_aligned_R7: assert property (@(posedge clk) disable iff (!rstN)
      chCmdPtr[i*32 +: 4] == 4'h0);

    assert_flush_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
      flushReq[i] |-> !chStatus[i*16+FLUSH_B]);

    assert_kick_active_R6: assert property (@(posedge clk) disable iff (!rstN)
      kick[i] |-> chStatus[i*16+ACTIVE_B]);

    assert_run_activates_R3: assert property (@(posedge clk) disable iff (!rstN)
      (ctlWr && busWrData[16+RUN_B] && busWrData[RUN_B]
             && busWrData[16+PAUSE_B] && !busWrData[PAUSE_B])
      |=> (chStatus[i*16+ACTIVE_B] && !chStatus[i*16+DEAD_B]));

    assert_run_stop_R4: assert property (@(posedge clk) disable iff (!rstN)
      (ctlWr && chStatus[i*16+RUN_B] && busWrData[16+RUN_B] && !busWrData[RUN_B])
      |=> (!chStatus[i*16+ACTIVE_B] && !chStatus[i*16+DEAD_B]));
  end

endmodule

bind dma_chan_regs dma_chan_regs_chk #(.NCH(NCH), .CH_SHIFT(CH_SHIFT)) chk_i (.*);

// File: tb/dma_chan_regs_tb_top.sv
`timescale 1ns/1ps
module dma_chan_regs_tb_top;
  localparam int NCH = 2;
  localparam int CH_SHIFT = 8;
  localparam int CH_W = 1;
  localparam int ADDR_W = CH_SHIFT + CH_W;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = '0;
  logic              busWrEn = 1'b0;
  logic              busWordAccess = 1'b1;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;
  logic              seqStatWe = 1'b0;
  logic [CH_W-1:0]   seqStatCh = '0;
  logic [15:0]       seqStatData = '0;
  logic [NCH*16-1:0] chStatus;
  logic [NCH*32-1:0] chCmdPtr, chIntrSel, chBranchSel, chWaitSel;
  logic [NCH-1:0]    flushReq, kick, fetchReq;

  int checks = 0;
  int fails = 0;
  bit done = 0;
  logic [NCH-1:0] snapFlush, snapKick, snapFetch;

  always #2 clk = ~clk;

  dma_chan_regs #(.NCH(NCH), .CH_SHIFT(CH_SHIFT)) dut_i (.*);

  function automatic logic [ADDR_W-1:0] ad(int ch, int off);
    return ADDR_W'((ch << CH_SHIFT) | off);
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
    end
  endtask

  task automatic busWrite(logic [ADDR_W-1:0] a, logic [31:0] d, bit word = 1);
    @(negedge clk);
    busAddr = a; busWrData = d; busWrEn = 1'b1; busWordAccess = word;
    @(negedge clk);
    busWrEn = 1'b0; busWordAccess = 1'b1;
    snapFlush = flushReq; snapKick = kick; snapFetch = fetchReq;
  endtask

  task automatic busRead(logic [ADDR_W-1:0] a, output logic [31:0] d, input bit word = 1);
    @(negedge clk);
    busAddr = a; busWordAccess = word;
    #1 d = busRdData;
    busWordAccess = 1'b1;
  endtask

  task automatic seqUpdate(int ch, logic [15:0] d);
    @(negedge clk);
    seqStatWe = 1'b1; seqStatCh = CH_W'(ch); seqStatData = d;
    @(negedge clk);
    seqStatWe = 1'b0;
  endtask

  task automatic tReset();
    logic [31:0] r;
    for (int c = 0; c < NCH; c++) begin
      busRead(ad(c, 'h04), r); check("R1 status", r, 0);
      busRead(ad(c, 'h0C), r); check("R1 cmdptr", r, 0);
      busRead(ad(c, 'h10), r); check("R1 intrsel", r, 0);
    end
    check("R1 pulses", {29'b0, |flushReq, |kick, |fetchReq}, 0);
  endtask

  task automatic tMerge();
    logic [31:0] r;
    busWrite(ad(0, 0), 32'h000F_0005);
    busRead(ad(0, 'h04), r); check("R2 devstat set", r, 32'h0005);
    busWrite(ad(0, 0), 32'h0003_000A);
    busRead(ad(0, 'h04), r); check("R2 partial mask", r, 32'h0006);
    busWrite(ad(0, 0), 32'h0D00_0D00);
    busRead(ad(0, 'h04), r); check("R2 protected bits", r, 32'h0006);
    check("R6 no kick when idle", snapKick, 0);
  endtask

  task automatic tRunPause();
    logic [31:0] r;
    busWrite(ad(0, 0), 32'h8000_8000);
    check("R6 kick on run", snapKick, 2'b01);
    busRead(ad(0, 'h04), r); check("R3 run activates", r, 32'h8406);
    busWrite(ad(0, 0), 32'h4000_4000);
    check("R6 no kick on pause", snapKick, 0);
    busRead(ad(0, 'h04), r); check("R3 pause deactivates", r, 32'hC006);
    busWrite(ad(0, 0), 32'h4000_0000);
    check("R6 kick on resume", snapKick, 2'b01);
    busRead(ad(0, 'h04), r); check("R3 resume", r, 32'h8406);
  endtask

  task automatic tStop();
    logic [31:0] r;
    seqUpdate(0, 16'h8C06);
    busRead(ad(0, 'h04), r); check("R10 seq update", r, 32'h8C06);
    busWrite(ad(0, 0), 32'h8000_0000);
    busRead(ad(0, 'h04), r); check("R4 run cleared", r, 32'h0006);
    check("R6 no kick after stop", snapKick, 0);
  endtask

  task automatic tWake();
    logic [31:0] r;
    busWrite(ad(1, 0), 32'h1000_1000);
    check("R6 kick on wake", snapKick, 2'b10);
    busRead(ad(1, 'h04), r); check("R3 wake activates", r, 32'h1400);
    seqUpdate(1, 16'h0800);
    busWrite(ad(1, 0), 32'h8000_8000);
    busRead(ad(1, 'h04), r); check("R3 run clears dead", r, 32'h8400);
  endtask

  task automatic tFlush();
    logic [31:0] r;
    busWrite(ad(1, 0), 32'h2000_2000);
    check("R5 flush pulse", snapFlush, 2'b10);
    check("R6 kick while active", snapKick, 2'b10);
    @(negedge clk);
    check("R5 flush one cycle", flushReq, 0);
    busRead(ad(1, 'h04), r); check("R5 flush self-clears", r, 32'h8400);
  endtask

  task automatic tPtr();
    logic [31:0] r;
    busWrite(ad(1, 'h0C), 32'h1234_5678);
    check("R7 no fetch when locked", snapFetch, 0);
    busRead(ad(1, 'h0C), r); check("R7 locked pointer", r, 0);
    busWrite(ad(0, 'h0C), 32'hABCD_EF17);
    check("R7 fetch pulse", snapFetch, 2'b01);
    busRead(ad(0, 'h0C), r); check("R7 aligned pointer", r, 32'hABCD_EF10);
  endtask

  task automatic tReads();
    logic [31:0] r;
    busWrite(ad(0, 'h10), 32'h000F_0003);
    busWrite(ad(0, 'h14), 32'h0001_0001);
    busWrite(ad(0, 'h18), 32'h00F0_00F0);
    busWrite(ad(0, 'h1C), 32'hFFFF_FFFF);
    busWrite(ad(0, 'h08), 32'hFFFF_FFFF);
    busRead(ad(0, 'h10), r); check("R8 intr select", r, 32'h000F_0003);
    busRead(ad(0, 'h14), r); check("R8 branch select", r, 32'h0001_0001);
    busRead(ad(0, 'h18), r); check("R8 wait select", r, 32'h00F0_00F0);
    busRead(ad(0, 'h00), r); check("R8 control reads zero", r, 0);
    busRead(ad(0, 'h1C), r); check("R8 xfer reads zero", r, 0);
    busRead(ad(0, 'h08), r); check("R8 ptr-high reads zero", r, 0);
  endtask

  task automatic tAccess();
    logic [31:0] r;
    busWrite(ad(0, 'h10), 32'h0000_0055, 0);
    busRead(ad(0, 'h10), r); check("R9 sub-word write ignored", r, 32'h000F_0003);
    busRead(ad(0, 'h10), r, 0); check("R9 sub-word read zero", r, 0);
    busWrite(ad(0, 'h12), 32'h0000_0066);
    busRead(ad(0, 'h10), r); check("R9 misaligned ignored", r, 32'h000F_0003);
    busWrite(ad(0, 'h20), 32'h0000_0077);
    busRead(ad(0, 'h20), r); check("R9 unmapped reads zero", r, 0);
    busWrite(ad(1, 'h10), 32'h0000_1111);
    busRead(ad(0, 'h10), r); check("R9 channel isolation", r, 32'h000F_0003);
    busRead(ad(1, 'h10), r); check("R9 channel select", r, 32'h0000_1111);
  endtask

  task automatic tCollide();
    logic [31:0] r;
    @(negedge clk);
    busAddr = ad(0, 'h04); busWrData = 32'h0000_0009; busWrEn = 1'b1;
    seqStatWe = 1'b1; seqStatCh = 0; seqStatData = 16'h000F;
    @(negedge clk);
    busWrEn = 1'b0; seqStatWe = 1'b0;
    busRead(ad(0, 'h04), r); check("R10 host wins", r, 32'h0009);
  endtask

  task automatic tMidReset();
    logic [31:0] r;
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(ad(1, 'h04), r); check("R1 reset status", r, 0);
    busRead(ad(0, 'h0C), r); check("R1 reset pointer", r, 0);
    busRead(ad(0, 'h18), r); check("R1 reset wait select", r, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    tReset();
    tMerge();
    tRunPause();
    tStop();
    tWake();
    tFlush();
    tPtr();
    tReads();
    tAccess();
    tCollide();
    tMidReset();
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule